// File: doc/BRIEF.md
# Watchdog Timer with Shaped Reset Output

This block is a watchdog that counts down a programmed number of time units and, when the countdown runs out, drives a reset output and records the event. Software controls it through two 8-bit registers. The control register holds the enable, the sticky expiry flag, the output shaping choices and the time unit. The count register holds the timeout length. Each unit is either one second or one minute. The block takes no oscillator: it counts a one-second tick input, and a one-millisecond tick input times the pulse widths.

On expiry the block sets the expiry flag and raises a single-cycle event that neighbouring registers can use to clear themselves. It also drives the reset output. In level mode the output holds until software clears the flag or disables the timer. In pulse mode the output is held for one of four fixed widths. The active polarity of the output can be chosen. Software keeps the system alive by rewriting the count register, which restarts the countdown.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control and count registers read 0, `timeout_evt` is 0, and `rst_out` is 1 (inactive, low-active polarity).
- R2: Control register (wr_sel=0) layout: bit 6 expiry flag, bit 5 enable, bit 4 output mode (1 = pulse), bit 3 unit (1 = minutes), bit 2 polarity (1 = active-high), bits 1:0 pulse width. Bits 5:0 read back as written, and bit 7 always reads 0.
- R3: With bit 3 = 0, enable set and count N > 0, the N-th `tick_s` pulse after the countdown loads causes expiry. The expiry sets bit 6 and raises `timeout_evt` for exactly one cycle, both visible in the cycle after the tick.
- R4: With bit 3 = 1, each count lasts 60 `tick_s` pulses, so count 2 expires on the 120th tick.
- R5: Writing 1 to bit 6 clears the flag. Writing 0 to it leaves the flag unchanged. An expiry in the same cycle as a clear wins.
- R6: In level mode the output is active from the cycle after `timeout_evt` and stays active until the flag is cleared or enable is cleared. It returns inactive within three cycles of that write.
- R7: In pulse mode the output is active for 1, 25, 125 or 5000 `tick_ms` pulses for width codes 0, 1, 2 and 3.
- R8: `rst_out` is high when active if bit 2 = 1, and low when active if bit 2 = 0. When idle it carries the opposite level.
- R9: Writing the count register (wr_sel=1) while enabled restarts the countdown from the new value. A rising enable loads the stored count.
- R10: A count of 0 with the timer enabled never expires.
- R11: While enable is 0, `tick_s` pulses do not advance the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = count register |
| wr_data | input | 8 | Write data |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| tick_s | input | 1 | One-cycle pulse per second |
| cfg_rd | output | 8 | Control register read value |
| time_rd | output | 8 | Count register read value |
| rst_out | output | 1 | Shaped reset output |
| timeout_evt | output | 1 | One-cycle expiry event |

## Verification
The assertions check the following on every cycle:
- the single-cycle event;
- that an expiry empties the countdown and always leaves the flag set;
- that a disabled timer holds its countdown;
- that a count of zero stays quiet;
- that the level state falls when the timer is disabled;
- that a pulse width counter only moves on millisecond ticks.

Only the bench scenarios can show the end-to-end figures: the tick counts to expiry in both units, the exact length of each pulse width under both polarities, the reload on a count write, and the release of the level output after a flag clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W = 8;

    typedef struct packed {
        logic       rsvd;
        logic       sts;
        logic       en;
        logic       pulse;
        logic       unit_min;
        logic       hact;
        logic [1:0] wsel;
    } wdt_cfg_t;

    typedef enum logic {
        OUT_LEVEL = 1'b0,
        OUT_PULSE = 1'b1
    } out_mode_e;

    function automatic int unsigned width_of(input logic [1:0] sel,
                                             input int unsigned w0,
                                             input int unsigned w1,
                                             input int unsigned w2,
                                             input int unsigned w3);
        case (sel)
            2'd0:    return w0;
            2'd1:    return w1;
            2'd2:    return w2;
            default: return w3;
        endcase
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          expire_i,
    output wdt_cfg_t      cfg_o,
    output logic [DW-1:0] count_o,
    output logic          load_o,
    output logic [DW-1:0] load_val_o
);

    wdt_cfg_t      cfg_q, cfg_nxt, wcfg;
    logic [DW-1:0] count_q;
    logic          cfg_wr, cnt_wr;

    assign cfg_wr = wr_en && !wr_sel;
    assign cnt_wr = wr_en && wr_sel;
    assign wcfg   = wdt_cfg_t'(wr_data[REG_W-1:0]);

    always_comb begin
        cfg_nxt = cfg_q;
        if (cfg_wr) begin
            cfg_nxt     = wcfg;
            cfg_nxt.sts = cfg_q.sts && !wcfg.sts;
        end
        if (expire_i) cfg_nxt.sts = 1'b1;
        cfg_nxt.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            count_q <= '0;
        end else begin
            cfg_q <= cfg_nxt;
            if (cnt_wr) count_q <= wr_data;
        end
    end

    assign cfg_o      = cfg_q;
    assign count_o    = count_q;
    assign load_o     = cnt_wr;
    assign load_val_o = cnt_wr ? wr_data : count_q;

    AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> cfg_q.sts); // R5

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int DW           = REG_W,
    parameter int MIN_PER_UNIT = 60
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          unit_min_i,
    input  logic          tick_s_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    output logic          expire_o
);

    localparam int PW = (MIN_PER_UNIT > 1) ? $clog2(MIN_PER_UNIT) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(MIN_PER_UNIT - 1);

    logic [DW-1:0] remain_q;
    logic [PW-1:0] pre_q;
    logic          en_q;
    logic          do_load, step, unit_done;

    assign do_load   = en_i && (!en_q || load_i);
    assign step      = en_i && !do_load && tick_s_i && (remain_q != '0);
    assign unit_done = !unit_min_i || (pre_q == PRE_LAST);
    assign expire_o  = step && unit_done && (remain_q == DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            pre_q    <= '0;
            en_q     <= 1'b0;
        end else begin
            en_q <= en_i;
            if (do_load) begin
                remain_q <= load_val_i;
                pre_q    <= '0;
            end else if (step) begin
                if (unit_done) begin
                    remain_q <= remain_q - DW'(1);
                    pre_q    <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end
        end
    end

    AST_EXPIRE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (remain_q == '0)); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(remain_q)); // R11
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en_i && remain_q == '0) |-> !expire_o); // R10

endmodule

// File: rtl/wdt_shaper.sv
module wdt_shaper
    import wdt_pkg::*;
#(
    parameter int unsigned W0 = 1,
    parameter int unsigned W1 = 25,
    parameter int unsigned W2 = 125,
    parameter int unsigned W3 = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire_i,
    input  logic       en_i,
    input  logic       sts_i,
    input  out_mode_e  mode_i,
    input  logic       hact_i,
    input  logic [1:0] wsel_i,
    input  logic       tick_ms_i,
    output logic       rst_out_o
);

    localparam int unsigned WMAX = max4(W0, W1, W2, W3);
    localparam int          LW   = $clog2(WMAX + 1);

    logic [LW-1:0] pulse_left_q;
    logic          lvl_on_q;
    logic          active;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_left_q <= '0;
            lvl_on_q     <= 1'b0;
            out_q        <= 1'b1;
        end else begin
            if (expire_i && mode_i == OUT_LEVEL) lvl_on_q <= 1'b1;
            else                                 lvl_on_q <= lvl_on_q && sts_i && en_i;

            if (expire_i && mode_i == OUT_PULSE)
                pulse_left_q <= LW'(width_of(wsel_i, W0, W1, W2, W3));
            else if (pulse_left_q != '0 && tick_ms_i)
                pulse_left_q <= pulse_left_q - LW'(1);

            out_q <= hact_i ? active : !active;
        end
    end

    assign active    = lvl_on_q || (pulse_left_q != '0);
    assign rst_out_o = out_q;

    AST_LVL_DROP: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !expire_i) |=> !lvl_on_q); // R6
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pulse_left_q != '0 && !tick_ms_i && !expire_i) |=> $stable(pulse_left_q)); // R7

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int          DW           = REG_W,
    parameter int          MIN_PER_UNIT = 60,
    parameter int unsigned W0           = 1,
    parameter int unsigned W1           = 25,
    parameter int unsigned W2           = 125,
    parameter int unsigned W3           = 5000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          tick_ms,
    input  logic          tick_s,
    output logic [DW-1:0] cfg_rd,
    output logic [DW-1:0] time_rd,
    output logic          rst_out,
    output logic          timeout_evt
);

    wdt_cfg_t      cfg;
    logic [DW-1:0] load_val;
    logic          load, expire, evt_q;

    wdt_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .expire_i(expire), .cfg_o(cfg), .count_o(time_rd),
        .load_o(load), .load_val_o(load_val)
    );

    wdt_counter #(.DW(DW), .MIN_PER_UNIT(MIN_PER_UNIT)) u_counter (
        .clk(clk), .rst(rst), .en_i(cfg.en), .unit_min_i(cfg.unit_min),
        .tick_s_i(tick_s), .load_i(load), .load_val_i(load_val), .expire_o(expire)
    );

    wdt_shaper #(.W0(W0), .W1(W1), .W2(W2), .W3(W3)) u_shaper (
        .clk(clk), .rst(rst), .expire_i(expire), .en_i(cfg.en), .sts_i(cfg.sts),
        .mode_i(out_mode_e'(cfg.pulse)), .hact_i(cfg.hact), .wsel_i(cfg.wsel),
        .tick_ms_i(tick_ms), .rst_out_o(rst_out)
    );

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= expire;
    end

    assign timeout_evt = evt_q;
    assign cfg_rd      = DW'(cfg);

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        timeout_evt |=> !timeout_evt); // R3

endmodule

// File: tb/test_wdt_timer.sv
module test_wdt_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick_ms = 1'b0;
    logic       tick_s = 1'b0;
    logic [7:0] cfg_rd, time_rd;
    logic       rst_out, timeout_evt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_timer i_wdt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_ms(tick_ms), .tick_s(tick_s), .cfg_rd(cfg_rd), .time_rd(time_rd),
        .rst_out(rst_out), .timeout_evt(timeout_evt)
    );

    // {width code, polarity, expected active cycles}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 16'd1},    {2'd0, 1'b1, 16'd1},
        {2'd1, 1'b0, 16'd25},   {2'd1, 1'b1, 16'd25},
        {2'd2, 1'b0, 16'd125},  {2'd2, 1'b1, 16'd125},
        {2'd3, 1'b0, 16'd5000}, {2'd3, 1'b1, 16'd5000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick_ms = 1'b0; tick_s = 1'b0; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk); tick_s = 1'b1;
        @(negedge clk); tick_s = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int evts;
        do_reset();
        // R1 reset state
        chk("R1 cfg", cfg_rd, 8'h00);
        chk("R1 count", time_rd, 8'h00);
        chk("R1 rst_out", rst_out, 1'b1);
        chk("R1 evt", timeout_evt, 1'b0);

        // R7 R8 pulse widths and polarity from the vector table
        for (int v = 0; v < NVEC; v++) begin
            int act;
            logic hact;
            hact = VEC[v][16];
            do_reset();
            wr(1'b1, 8'd1);
            wr(1'b0, {2'b00, 1'b1, 1'b1, 1'b0, hact, VEC[v][18:17]});
            idle(2);
            tick_ms = 1'b1;
            one_tick();
            act = 0;
            for (int c = 0; c < int'(VEC[v][15:0]) + 10; c++) begin
                @(negedge clk);
                if (rst_out == hact) act++;
            end
            chk("R7 R8 pulse width", act, VEC[v][15:0]);
            chk("R8 idle level", rst_out, !hact);
            tick_ms = 1'b0;
        end

        // R2 field read back, bit 7 zero
        do_reset();
        wr(1'b0, 8'hFF);
        chk("R2 readback", cfg_rd, 8'h3F);
        // R10 zero count never expires
        evts = 0;
        for (int i = 0; i < 20; i++) begin one_tick(); evts += timeout_evt; end
        chk("R10 no events", evts, 0);
        chk("R10 flag clear", cfg_rd[6], 1'b0);

        // R3 seconds countdown, level output, high polarity
        do_reset();
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h24);
        idle(2);
        one_tick(); one_tick();
        chk("R3 no early expiry", {timeout_evt, cfg_rd[6]}, 2'b00);
        one_tick();
        chk("R3 event and flag", {timeout_evt, cfg_rd[6]}, 2'b11);
        @(negedge clk);
        chk("R3 event single cycle", timeout_evt, 1'b0);
        chk("R6 level active", rst_out, 1'b1);
        wr(1'b0, 8'h24);
        idle(5);
        chk("R5 write zero keeps flag", cfg_rd[6], 1'b1);
        chk("R6 level holds", rst_out, 1'b1);
        wr(1'b0, 8'h64);
        idle(3);
        chk("R5 write one clears", cfg_rd[6], 1'b0);
        chk("R6 release on clear", rst_out, 1'b0);

        // R6 release on disable
        wr(1'b1, 8'd1);
        one_tick();
        chk("R6 second expiry", cfg_rd[6], 1'b1);
        idle(1);
        chk("R6 active again", rst_out, 1'b1);
        wr(1'b0, 8'h04);
        idle(3);
        chk("R6 release on disable", rst_out, 1'b0);
        chk("R6 flag survives disable", cfg_rd[6], 1'b1);

        // R4 minute units
        do_reset();
        wr(1'b1, 8'd2);
        wr(1'b0, 8'h2C);
        idle(2);
        evts = 0;
        for (int i = 0; i < 119; i++) begin one_tick(); evts += timeout_evt; end
        chk("R4 quiet after 119 ticks", evts, 0);
        one_tick();
        chk("R4 expiry on 120th tick", timeout_evt, 1'b1);

        // R9 reload on count write
        do_reset();
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h24);
        idle(2);
        one_tick(); one_tick();
        wr(1'b1, 8'd3);
        one_tick(); one_tick();
        chk("R9 reload delays expiry", cfg_rd[6], 1'b0);
        one_tick();
        chk("R9 expiry after reload", cfg_rd[6], 1'b1);

        // R11 disabled does not count, enable loads stored count
        do_reset();
        wr(1'b1, 8'd1);
        wr(1'b0, 8'h04);
        for (int i = 0; i < 5; i++) one_tick();
        chk("R11 no expiry while disabled", cfg_rd[6], 1'b0);
        wr(1'b0, 8'h24);
        idle(2);
        one_tick();
        chk("R11 R9 expiry after enable", cfg_rd[6], 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule